// File: doc/BRIEF.md
# S/PDIF Channel Status Capture

This block gathers the 192-bit channel status block that an S/PDIF stream spreads one bit per subframe across 192 frames. An upstream decoder delivers one strobe per received subframe, together with a 2-bit preamble class and that subframe's channel status bit. A single select input decides whether the first subframe of each frame (channel A) or the second (channel B) is collected. Collected bits are assembled in a shadow buffer. The visible copy is replaced in one step only once a complete block has arrived.

The visible 192 bits are read as six 32-bit words through a 3-bit word index. The result always reflects the last complete block of the chosen channel. An interrupted block never shows up partly written.

Top module: `spdif_cs_capture`

## Requirements
- R1: After synchronous reset, every readable status word is zero and capture is idle until a block-start subframe arrives.
- R2: A strobed subframe with preamble code 2'b00 (block start, channel A of frame 0) restarts the block at status bit 0. When channel A is selected, that subframe's bit is stored as bit 0.
- R3: With `chan_sel`=0, subframes coded 2'b00 and 2'b01 are collected. With `chan_sel`=1, subframes coded 2'b10 are collected. Subframes of the other channel and subframes coded 2'b11 leave the status unchanged.
- R4: Block bit n (n counted from 0 at the block start) appears in word n/32 at bit n%32. Status byte k therefore sits in word k/4 at bits 8(k%4)+7..8(k%4), with its first-received bit in the LSB.
- R5: `word_sel` values 0 to 5 present the matching word. Values 6 and 7 present zero.
- R6: The readable words keep their previous contents until the 192nd bit of a block is stored. All six words then change together, visible from the clock edge that stores that bit.
- R7: A block cut short by a new block start before its 192nd bit is discarded, and the readable words keep the previous complete block.
- R8: Collected-channel subframes that arrive after a completed block, or before any block start since reset, are ignored until the next block start.
- R9: Any change of `chan_sel` abandons the block in progress. Capture resumes only at the next block start.
- R10: Inputs presented while `sf_valid` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sf_valid | input | 1 | One-cycle strobe marking a decoded subframe |
| sf_pre | input | 2 | Preamble class: 00 block start, 01 channel A, 10 channel B, 11 ignored |
| sf_cbit | input | 1 | Channel status bit carried by the subframe |
| chan_sel | input | 1 | 0 collects channel A, 1 collects channel B |
| word_sel | input | 3 | Index of the 32-bit status word to present |
| status_word | output | 32 | Selected word of the last complete status block |

## Verification
A bit counter that is off by one shifts every byte, so it shows at the ports as a whole block of mismatched words on the very next full block. A counter that wraps instead of saturating, or that stays armed after completion, corrupts the visible words within one block of stray subframes. A commit that fires early, or that misses the abandon caused by a truncation or a channel change, shows up as words changing before the 192nd bit. The bench reads all eight word indexes both just before and just after the bit that should complete a block.

// File: rtl/spdif_cs_pkg.sv
package spdif_cs_pkg;

    localparam int CS_BITS   = 192;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = CS_BITS / WORD_W;
    localparam int SEL_W     = 3;
    localparam int IDX_W     = $clog2(CS_BITS + 1);

    typedef enum logic [1:0] {
        PRE_BLOCK = 2'b00,
        PRE_CHA   = 2'b01,
        PRE_CHB   = 2'b10,
        PRE_RSVD  = 2'b11
    } pre_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic             bit_val;
        logic             commit;
    } cs_wr_t;

    typedef logic [WORD_W-1:0] cs_word_t;

    function automatic logic subframe_is_ours(input pre_e p, input logic ch_b);
        if (ch_b) return p == PRE_CHB;
        return (p == PRE_BLOCK) || (p == PRE_CHA);
    endfunction

endpackage

// File: rtl/cs_bit_sequencer.sv
module cs_bit_sequencer
    import spdif_cs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sf_valid,
    input  pre_e             sf_pre,
    input  logic             sf_cbit,
    input  logic             chan_sel,
    output cs_wr_t           wr,
    output logic [IDX_W-1:0] bit_idx,
    output logic             armed
);

    logic chan_q;
    logic chan_chg;
    logic is_start;
    logic own;

    always_comb begin
        chan_chg   = chan_sel != chan_q;
        is_start   = sf_valid && (sf_pre == PRE_BLOCK);
        own        = sf_valid && subframe_is_ours(sf_pre, chan_sel);
        wr.idx     = is_start ? '0 : bit_idx;
        wr.bit_val = sf_cbit;
        wr.en      = !chan_chg && own && (is_start || armed);
        wr.commit  = wr.en && (wr.idx == IDX_W'(CS_BITS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q  <= 1'b0;
            armed   <= 1'b0;
            bit_idx <= '0;
        end else begin
            chan_q <= chan_sel;
            if (chan_chg) begin
                armed   <= 1'b0;
                bit_idx <= '0;
            end else if (is_start) begin
                armed   <= 1'b1;
                bit_idx <= own ? IDX_W'(1) : '0;
            end else if (wr.en) begin
                bit_idx <= bit_idx + IDX_W'(1);
                if (wr.commit) armed <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cs_shadow_store.sv
module cs_shadow_store
    import spdif_cs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  cs_wr_t             wr,
    output logic [CS_BITS-1:0] visible
);

    logic [CS_BITS-1:0] shadow;
    logic [CS_BITS-1:0] shadow_nx;

    always_comb begin
        shadow_nx = shadow;
        if (wr.en) shadow_nx[wr.idx] = wr.bit_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '0;
            visible <= '0;
        end else begin
            shadow <= shadow_nx;
            if (wr.commit) visible <= shadow_nx;
        end
    end

endmodule

// File: rtl/cs_word_mux.sv
module cs_word_mux
    import spdif_cs_pkg::*;
(
    input  logic [CS_BITS-1:0] visible,
    input  logic [SEL_W-1:0]   sel,
    output cs_word_t           word
);

    cs_word_t words [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_split
        assign words[g] = visible[g*WORD_W +: WORD_W];
    end

    always_comb begin
        word = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (sel == SEL_W'(w)) word = words[w];
        end
    end

endmodule

// File: rtl/spdif_cs_capture.sv
module spdif_cs_capture
    import spdif_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sf_valid,
    input  logic [1:0]        sf_pre,
    input  logic              sf_cbit,
    input  logic              chan_sel,
    input  logic [SEL_W-1:0]  word_sel,
    output logic [WORD_W-1:0] status_word
);

    cs_wr_t             wr;
    logic               commit;
    logic [IDX_W-1:0]   bit_idx;
    logic               armed;
    logic [CS_BITS-1:0] visible;

    assign commit = wr.commit;

    cs_bit_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .sf_valid (sf_valid),
        .sf_pre   (pre_e'(sf_pre)),
        .sf_cbit  (sf_cbit),
        .chan_sel (chan_sel),
        .wr       (wr),
        .bit_idx  (bit_idx),
        .armed    (armed)
    );

    cs_shadow_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .visible (visible)
    );

    cs_word_mux u_mux (
        .visible (visible),
        .sel     (word_sel),
        .word    (status_word)
    );

endmodule

// File: rtl/cs_capture_checker.sv
module cs_capture_checker
    import spdif_cs_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               sf_valid,
    input logic [1:0]         sf_pre,
    input logic               chan_sel,
    input logic [SEL_W-1:0]   word_sel,
    input logic [WORD_W-1:0]  status_word,
    input logic [IDX_W-1:0]   bit_idx,
    input logic               armed,
    input logic               commit,
    input logic [CS_BITS-1:0] visible
);

    logic prev_chan;

    always_ff @(posedge clk) begin
        if (rst) prev_chan <= 1'b0;
        else     prev_chan <= chan_sel;
    end

    assert_idx_bound_R8: assert property (@(posedge clk) disable iff (rst)
        bit_idx <= IDX_W'(CS_BITS));

    assert_visible_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(visible));

    assert_commit_full_R6: assert property (@(posedge clk) disable iff (rst)
        commit |-> (armed && bit_idx == IDX_W'(CS_BITS - 1)));

    assert_sel_range_R5: assert property (@(posedge clk) disable iff (rst)
        (word_sel >= SEL_W'(NUM_WORDS)) |-> (status_word == '0));

    assert_block_start_R2: assert property (@(posedge clk) disable iff (rst)
        (sf_valid && sf_pre == 2'b00 && chan_sel == prev_chan)
        |=> (armed && bit_idx == ($past(chan_sel) ? IDX_W'(0) : IDX_W'(1))));

    assert_chan_switch_R9: assert property (@(posedge clk) disable iff (rst)
        (chan_sel != prev_chan) |=> !armed);

endmodule

bind spdif_cs_capture cs_capture_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .sf_valid    (sf_valid),
    .sf_pre      (sf_pre),
    .chan_sel    (chan_sel),
    .word_sel    (word_sel),
    .status_word (status_word),
    .bit_idx     (bit_idx),
    .armed       (armed),
    .commit      (commit),
    .visible     (visible)
);

// File: tb/spdif_cs_capture_test.sv
`timescale 1ns/1ps
module spdif_cs_capture_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sf_valid = 1'b0;
    logic [1:0]  sf_pre = 2'b01;
    logic        sf_cbit = 1'b0;
    logic        chan_sel = 1'b0;
    logic [2:0]  word_sel = 3'd0;
    logic [31:0] status_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spdif_cs_capture uut (
        .clk (clk), .rst (rst), .sf_valid (sf_valid), .sf_pre (sf_pre),
        .sf_cbit (sf_cbit), .chan_sel (chan_sel), .word_sel (word_sel),
        .status_word (status_word)
    );

    // {channel, seed}: channel A collects mkpat(seed), channel B mkpat(~seed)
    localparam logic [32:0] TBL [4] = '{
        {1'b0, 32'h1234_5678},
        {1'b1, 32'hA5C3_0F96},
        {1'b1, 32'h0000_0001},
        {1'b0, 32'hDEAD_BEEF}
    };

    function automatic logic [191:0] mkpat(input logic [31:0] s);
        logic [191:0] p;
        for (int i = 0; i < 6; i++)
            p[32*i +: 32] = (s * 32'(2*i + 3)) ^ {s[7:0], s[31:8]} ^ (32'h0101_0101 * 32'(i));
        return p;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [191:0] exp);
        for (int w = 0; w < 8; w++) begin
            word_sel = 3'(w);
            #1;
            check(req, status_word, (w < 6) ? exp[32*w +: 32] : 32'h0);
        end
    endtask

    task automatic sf(input logic [1:0] pre, input logic c);
        sf_valid = 1'b1;
        sf_pre   = pre;
        sf_cbit  = c;
        @(posedge clk);
        #1;
        sf_valid = 1'b0;
        sf_pre   = 2'b01;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // frames first..last of a two-channel stream; gap inserts an invalid
    // block-start cycle and a strobed reserved-code subframe after each subframe
    task automatic send_range(input logic [191:0] a, input logic [191:0] b,
                              input int first, input int last, input bit gap);
        for (int f = first; f <= last; f++) begin
            sf((f == 0) ? 2'b00 : 2'b01, a[f]);
            if (gap) begin
                sf_pre = 2'b00; sf_cbit = ~a[f]; idle(1);
                sf(2'b11, ~a[f]);
            end
            sf(2'b10, b[f]);
            if (gap) begin
                sf_pre = 2'b00; sf_cbit = ~b[f]; idle(1);
                sf(2'b11, ~b[f]);
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [191:0] cur, y, z, w, p, g;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1: reset state
        check_all("R1", '0);

        // R8: no block start since reset, subframes ignored
        send_range({192{1'b1}}, {192{1'b1}}, 1, 191, 0);
        check_all("R8 before start", '0);

        // R3 R4 R5: table of channel/pattern vectors
        for (int t = 0; t < 4; t++) begin
            chan_sel = TBL[t][32];
            idle(2);
            send_range(mkpat(TBL[t][31:0]), mkpat(~TBL[t][31:0]), 0, 191, 0);
            cur = TBL[t][32] ? mkpat(~TBL[t][31:0]) : mkpat(TBL[t][31:0]);
            check_all("R3 R4 R5 table", cur);
        end

        // R6: words hold until the 192nd bit, then change together
        y = mkpat(32'h0BAD_F00D);
        send_range(y, ~y, 0, 190, 0);
        check_all("R6 before last bit", cur);
        sf(2'b01, y[191]);
        check_all("R6 after last bit", y);
        sf(2'b10, ~y[191]);

        // R8: bits after a completed block ignored
        send_range(~y, y, 1, 40, 0);
        check_all("R8 after completion", y);

        // R7: truncated block discarded
        z = mkpat(32'h7777_1111);
        send_range(z, ~z, 0, 99, 0);
        check_all("R7 truncated", y);
        w = mkpat(32'h3141_5926);
        send_range(w, ~w, 0, 191, 0);
        check_all("R7 following block", w);

        // R9: channel toggle abandons the block in progress
        p = mkpat(32'h2718_2818);
        send_range(p, ~p, 0, 149, 0);
        chan_sel = 1'b1; idle(1);
        chan_sel = 1'b0; idle(1);
        send_range(p, ~p, 150, 191, 0);
        check_all("R9 channel toggle", w);

        // R10 R3: invalid strobes and reserved-code subframes interleaved
        g = mkpat(32'hC0FF_EE00);
        send_range(g, ~g, 0, 191, 1);
        check_all("R10 R3 gaps", g);

        // R2 R3: channel B with gaps, block start carries no B bit
        chan_sel = 1'b1;
        idle(2);
        send_range(~g, g ^ {6{32'h5A5A_5A5A}}, 0, 191, 1);
        check_all("R2 R3 channel B", g ^ {6{32'h5A5A_5A5A}});

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule